// File: doc/BRIEF.md
# Modulo Rate Accumulator Divider

This block derives a low-rate event stream from a fast input clock so that the long-term average rate is exact. The ratio is set by two integer parameters: an increment `INC` and a modulus `MOD`, with 0 < INC < MOD. On every enabled clock, a residue register advances by `INC` modulo `MOD`. Each time the residue passes the modulus, a single-clock pulse is issued. Over any `MOD` enabled clocks exactly `INC` pulses appear, so the output rate is Fin·INC/MOD with no long-term drift.

The default ratio is 256/78125. This is the 32768/10,000,000 ratio after a common factor of 2^7 has been removed, so a 17-bit residue is enough. At a 10 MHz input the pattern repeats every 1/128 s. Only one adder is used. A mux chooses its second operand: either `INC` or `INC-MOD` in two's complement, so the add and the wrap-around subtraction happen in a single pass. An optional toggle stage turns the pulses into a square wave at half the pulse rate. To get a square wave at a target frequency, set the ratio to twice that frequency. The output edges carry up to one input period of peak-to-peak jitter. There is no streaming data path, so all pins are plain control and status signals.

Top module: `rate_accum_div`

## Requirements
- R1: While `rst_ni` is low, `acc_o`, `pulse_o` and `square_o` are all 0.
- R2: On an enabled clock where acc+INC < MOD, `acc_o` becomes acc+INC and `pulse_o` is 0 in the following cycle.
- R3: On an enabled clock where acc+INC >= MOD (including acc exactly MOD-INC), `acc_o` becomes acc+INC-MOD and `pulse_o` is 1 for exactly that one following cycle.
- R4: `acc_o` is always below MOD.
- R5: On a clock with `en_i` low, `acc_o` and `square_o` keep their values and `pulse_o` is 0 in the following cycle, even when the residue is at the wrap threshold.
- R6: `square_o` changes value in exactly those cycles in which `pulse_o` is 1 (with the square stage enabled).
- R7: Any run of MOD consecutive enabled clocks produces exactly INC pulses and leaves `acc_o` at its starting value.
- R8: The number of enabled clocks from one pulse to the next is always floor(MOD/INC) or ceil(MOD/INC), which is 305 or 306 for the defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock whose rate is divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance enable; the state is frozen when this is low |
| pulse_o | output | 1 | One-clock pulse for each modulus wrap |
| square_o | output | 1 | Toggles on each pulse (tied to 0 if the square stage is disabled) |
| acc_o | output | $clog2(MOD) | Current residue, always below MOD |

## Verification
The hardest conditions to reach from the ports are the full period and the exact wrap boundary. The residue visits MOD-INC only once in 78125 enabled clocks, and the claim that the period closes on itself needs a whole period of stimulus. The bench therefore runs one complete period from reset, comparing every cycle against an integer model. It then steps until the model residue sits at the wrap threshold, drops enable there to show that the pending wrap is held back, and finally runs a second full period that starts from that nonzero residue.

// File: rtl/rate_div_pkg.sv
package rate_div_pkg;

  function automatic int unsigned div_floor(input int unsigned num, input int unsigned den);
    return num / den;
  endfunction

  function automatic int unsigned div_ceil(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/rate_div_addend_sel.sv
module rate_div_addend_sel #(
  parameter int unsigned INC   = 256,
  parameter int unsigned MOD   = 78125,
  parameter int unsigned ACC_W = 17
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic             wrap_o,
  output logic [ACC_W-1:0] addend_o
);
  localparam int unsigned     THRESH    = MOD - INC;
  localparam logic [ACC_W:0]  WRAP_WIDE = (ACC_W+1)'((2**ACC_W) + INC - MOD);
  localparam logic [ACC_W-1:0] ADD_STEP = ACC_W'(INC);
  localparam logic [ACC_W-1:0] ADD_WRAP = WRAP_WIDE[ACC_W-1:0];

  // Wrap when the residue plus the step would reach the modulus.
  assign wrap_o   = ({1'b0, acc_i} >= (ACC_W+1)'(THRESH));
  // The negative operand is taken modulo 2^ACC_W, so one adder both steps and wraps.
  assign addend_o = wrap_o ? ADD_WRAP : ADD_STEP;

endmodule

// File: rtl/rate_div_acc.sv
module rate_div_acc #(
  parameter int unsigned INC   = 256,
  parameter int unsigned MOD   = 78125,
  parameter int unsigned ACC_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wrap_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             pulse_o
);
  logic [ACC_W-1:0] acc_q;
  logic             pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= en_i & wrap_i;
      if (en_i) acc_q <= acc_q + addend_i;
    end
  end

  assign acc_o   = acc_q;
  assign pulse_o = pulse_q;

  p_acc_below_mod_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(acc_q) < MOD);

  p_plain_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (32'(acc_q) + INC < MOD)) |=>
      ((32'(acc_q) == 32'($past(acc_q)) + INC) && !pulse_q));

  p_wrap_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (32'(acc_q) + INC >= MOD)) |=>
      ((32'(acc_q) + MOD == 32'($past(acc_q)) + INC) && pulse_q));

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(acc_q) && !pulse_q));

endmodule

// File: rtl/rate_div_square.sv
module rate_div_square #(
  parameter bit SQUARE_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wrap_i,
  input  logic pulse_i,
  output logic square_o
);
  generate
    if (SQUARE_EN) begin : g_toggle
      logic sq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             sq_q <= 1'b0;
        else if (en_i && wrap_i) sq_q <= ~sq_q;
      end
      assign square_o = sq_q;

      p_square_follows_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sq_q != $past(sq_q)) == pulse_i);
    end else begin : g_none
      logic unused_w;
      assign unused_w = clk_i ^ rst_ni ^ en_i ^ wrap_i ^ pulse_i;
      assign square_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/rate_accum_div.sv
module rate_accum_div #(
  parameter int unsigned INC       = 256,
  parameter int unsigned MOD       = 78125,
  parameter bit          SQUARE_EN = 1'b1,
  localparam int unsigned ACC_W    = $clog2(MOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic             pulse_o,
  output logic             square_o,
  output logic [ACC_W-1:0] acc_o
);
  import rate_div_pkg::*;

  localparam int unsigned GAP_LO = div_floor(MOD, INC);
  localparam int unsigned GAP_HI = div_ceil(MOD, INC);
  localparam int unsigned GAP_W  = $clog2(GAP_HI + 1) + 1;

  logic             wrap_w;
  logic [ACC_W-1:0] addend_w;
  logic [ACC_W-1:0] acc_w;
  logic             pulse_w;

  rate_div_addend_sel #(.INC(INC), .MOD(MOD), .ACC_W(ACC_W)) u_sel (
    .acc_i    (acc_w),
    .wrap_o   (wrap_w),
    .addend_o (addend_w)
  );

  rate_div_acc #(.INC(INC), .MOD(MOD), .ACC_W(ACC_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .wrap_i   (wrap_w),
    .addend_i (addend_w),
    .acc_o    (acc_w),
    .pulse_o  (pulse_w)
  );

  rate_div_square #(.SQUARE_EN(SQUARE_EN)) u_sq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .wrap_i   (wrap_w),
    .pulse_i  (pulse_w),
    .square_o (square_o)
  );

  assign acc_o   = acc_w;
  assign pulse_o = pulse_w;

  // Spacing monitor: counts enabled clocks since the last wrap.
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (en_i) begin
      if (wrap_w) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q  <= gap_q + 1'b1;
      end
    end
  end

  p_gap_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wrap_w && seen_q) |->
      ((32'(gap_q) + 1 >= GAP_LO) && (32'(gap_q) + 1 <= GAP_HI)));

endmodule

// File: tb/rate_accum_div_tb.sv
module rate_accum_div_tb_top;
  localparam int unsigned INC    = 256;
  localparam int unsigned MOD    = 78125;
  localparam int unsigned GAP_LO = MOD / INC;
  localparam int unsigned GAP_HI = (MOD + INC - 1) / INC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        pulse;
  logic        square;
  logic [16:0] acc;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  int unsigned ref_acc = 0;
  bit          ref_p = 1'b0;
  bit          ref_sq = 1'b0;
  int          gap = 0;
  bit          seen = 1'b0;
  int          pulse_total = 0;

  always #4 clk = ~clk;

  rate_accum_div dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .en_i     (en),
    .pulse_o  (pulse),
    .square_o (square),
    .acc_o    (acc)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // One clock: apply en_v, advance the model, compare after the edge.
  task automatic step(input bit en_v);
    en = en_v;
    @(posedge clk);
    if (en_v) begin
      gap++;
      if (ref_acc + INC >= MOD) begin
        ref_acc = ref_acc + INC - MOD;
        ref_p = 1'b1;
        ref_sq = ~ref_sq;
      end else begin
        ref_acc = ref_acc + INC;
        ref_p = 1'b0;
      end
    end else begin
      ref_p = 1'b0;
    end
    @(negedge clk);
    chk(acc == ref_acc[16:0], ref_p ? "R3 acc wrap" : (en_v ? "R2 acc step" : "R5 acc hold"),
        longint'(acc), longint'(ref_acc));
    chk(pulse == ref_p, en_v ? "R3 pulse" : "R5 pulse", longint'(pulse), longint'(ref_p));
    chk(square == ref_sq, en_v ? "R6 square" : "R5 square", longint'(square), longint'(ref_sq));
    chk(32'(acc) < MOD, "R4 acc range", longint'(acc), longint'(MOD - 1));
    if (ref_p) begin
      if (seen) chk(gap >= GAP_LO && gap <= GAP_HI, "R8 gap", longint'(gap), longint'(GAP_HI));
      seen = 1'b1;
      gap = 0;
      pulse_total++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk(acc == 0, "R1 acc", longint'(acc), 0);
    chk(pulse == 0, "R1 pulse", longint'(pulse), 0);
    chk(square == 0, "R1 square", longint'(square), 0);
    en = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_full_period();
    int start_pulses;
    start_pulses = pulse_total;
    for (int k = 0; k < int'(MOD); k++) step(1'b1);
    chk(pulse_total - start_pulses == int'(INC), "R7 pulses per period",
        longint'(pulse_total - start_pulses), longint'(INC));
    chk(acc == 0, "R7 period closes", longint'(acc), 0);
  endtask

  task automatic t_hold_at_threshold();
    logic [16:0] frozen;
    for (int k = 0; k < 400 && (ref_acc + INC < MOD); k++) step(1'b1);
    chk(32'(acc) + INC >= MOD, "R5 reached threshold", longint'(acc), longint'(MOD - INC));
    frozen = acc;
    for (int k = 0; k < 20; k++) step(1'b0);
    chk(acc == frozen, "R5 frozen residue", longint'(acc), longint'(frozen));
    step(1'b1);
    chk(pulse == 1'b1, "R3 wrap after resume", longint'(pulse), 1);
    step(1'b1);
    chk(pulse == 1'b0, "R3 single-clock pulse", longint'(pulse), 0);
  endtask

  task automatic t_offset_period();
    int start_pulses;
    logic [16:0] start_acc;
    for (int k = 0; k < 37; k++) step(1'b1);
    start_acc = acc;
    start_pulses = pulse_total;
    for (int k = 0; k < int'(MOD); k++) step(1'b1);
    chk(pulse_total - start_pulses == int'(INC), "R7 pulses offset period",
        longint'(pulse_total - start_pulses), longint'(INC));
    chk(acc == start_acc, "R7 offset period closes", longint'(acc), longint'(start_acc));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 199000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 199000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_full_period();
    t_hold_at_threshold();
    t_offset_period();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule